// File: doc/BRIEF.md
# Wide Operand Store for a Modular Exponentiation Engine

This block holds the working numbers of a modular exponentiation engine. There are four operand slots and two modulus slots. Each slot is as wide as the multiplier pipeline, set by the parameter `TOTAL_BITS`. A processor reaches the store one 32-bit word at a time through a request channel with a valid/ready handshake. The multiplier core reads a whole slot in one access and writes a whole operand back in one access.

The processor address has two fields. The upper three bits pick a slot and the lower six bits pick a word inside it. Each slot therefore spans 64 words, which is room for 2048 bits, whether or not the pipeline is that wide. A one-bit modulus choice tells the core which of the two stored moduli to use.

When only the upper part of a split pipeline is in use, software must write zeros into the lower word positions of each operand. The store does not do this by itself.

Back-pressure rules for the request channel:
- A request is taken on a clock edge where both `bus_req_valid` and `bus_req_ready` are high.
- While a request waits, its fields must stay stable.
- The store lowers `bus_req_ready` only in one case: a processor write aims at the same operand slot that the core is writing in that cycle.
- The read response has no ready signal. The processor must take the response in the cycle that `bus_rsp_valid` is high.

Top module: `mod_word_mem`

## Requirements
- R1: After reset, every stored word reads as zero. Both response valids are low and `bus_req_ready` is high.
- R2: An accepted processor read gives exactly one `bus_rsp_valid` pulse, in the cycle after acceptance, carrying the addressed word. An accepted write gives no response, and a read returns the last word written at that address.
- R3: Address bits [8:6] select the slot: 0 to 3 are operands, 4 is modulus A and 5 is modulus B. Bits [5:0] select the word. Word w holds bits [32w+31:32w] of the slot.
- R4: Writes to slot codes 6 and 7 are ignored, and so are writes to word indices at or beyond `TOTAL_BITS/32`. Reads at those addresses return zero.
- R5: A core read with `core_rd_is_mod` low returns the full operand `core_rd_idx`. `core_rd_valid` and `core_rd_data` appear one cycle after `core_rd_en`.
- R6: A core read with `core_rd_is_mod` high returns modulus A when `mod_sel` is 0 and modulus B when `mod_sel` is 1, whatever the value of `core_rd_idx`.
- R7: A core write replaces all `TOTAL_BITS` of operand slot `core_wr_idx` in one cycle, and the new value is visible to both ports afterwards.
- R8: A processor write to the operand slot that the core writes in the same cycle is held with `bus_req_ready` low. The core data is stored first, and the held word is stored once accepted.
- R9: `bus_req_ready` stays high whenever there is no core write. It also stays high when the core write targets a different slot from the processor request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_sel | input | 1 | Picks modulus A (0) or B (1) for core reads |
| bus_req_valid | input | 1 | Processor request present |
| bus_req_ready | output | 1 | Store accepts the request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Slot field [8:6], word field [5:0] |
| bus_wdata | input | 32 | Write word |
| bus_rsp_valid | output | 1 | Read response present (no back-pressure) |
| bus_rsp_data | output | 32 | Read word |
| core_rd_en | input | 1 | Core read request |
| core_rd_is_mod | input | 1 | Read a modulus instead of an operand |
| core_rd_idx | input | 2 | Operand slot for core reads |
| core_rd_valid | output | 1 | Core read data present |
| core_rd_data | output | TOTAL_BITS | Full-width read data |
| core_wr_en | input | 1 | Core write of a full operand |
| core_wr_idx | input | 2 | Operand slot for core writes |
| core_wr_data | input | TOTAL_BITS | Full-width write data |

## Verification
The assertions check every cycle that:
- each accepted read produces exactly one response in the next cycle, and no response appears without one;
- reads at unmapped or out-of-range addresses return zero;
- core reads have a latency of one cycle;
- `bus_req_ready` falls only while a core write competes with a processor write.

Only the bench's scenarios can show that stored words land in the right slot and bit positions. The same holds for the modulus choice, for full-width core writes meeting word-wide processor access, and for the held processor word landing after the core data. For these, the bench sweeps every address of a small configuration and compares against a model it computes itself.

// File: rtl/omem_pkg.sv
package omem_pkg;
  localparam int WORD_W    = 32;
  localparam int SLOT_W    = 3;
  localparam int WIDX_W    = 6;
  localparam int ADDR_W    = SLOT_W + WIDX_W;
  localparam int NUM_OPS   = 4;
  localparam int MOD_BASE  = 4;
  localparam int NUM_MODS  = 2;
  localparam int NUM_SLOTS = NUM_OPS + NUM_MODS;
  localparam int OPIDX_W   = $clog2(NUM_OPS);
endpackage

// File: rtl/omem_addr_dec.sv
module omem_addr_dec
  import omem_pkg::*;
#(
  parameter int NWORDS = 48
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SLOT_W-1:0] slot,
  output logic [WIDX_W-1:0] widx,
  output logic              hit
);
  assign slot = addr[ADDR_W-1:WIDX_W];
  assign widx = addr[WIDX_W-1:0];
  // Mapped only if the slot exists and the word lies inside the configured width.
  assign hit  = (int'(slot) < NUM_SLOTS) && (int'(widx) < NWORDS);
endmodule

// File: rtl/omem_slot_bank.sv
module omem_slot_bank
  import omem_pkg::*;
#(
  parameter int NWORDS = 48,
  localparam int BITS  = NWORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_we,
  input  logic [WIDX_W-1:0] widx,
  input  logic [WORD_W-1:0] word_wdata,
  output logic [WORD_W-1:0] word_q,
  input  logic              full_we,
  input  logic [BITS-1:0]   full_wdata,
  output logic [BITS-1:0]   full_q
);
  logic [NWORDS-1:0][WORD_W-1:0] words;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words <= '0;
    end else if (full_we) begin
      words <= full_wdata;
    end else if (word_we) begin
      for (int w = 0; w < NWORDS; w++) begin
        if (widx == WIDX_W'(w)) words[w] <= word_wdata;
      end
    end
  end

  always_comb begin
    word_q = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (widx == WIDX_W'(w)) word_q = words[w];
    end
  end

  assign full_q = words;
endmodule

// File: rtl/mod_word_mem.sv
module mod_word_mem
  import omem_pkg::*;
#(
  parameter int TOTAL_BITS = 1536
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mod_sel,
  input  logic                  bus_req_valid,
  output logic                  bus_req_ready,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [WORD_W-1:0]     bus_wdata,
  output logic                  bus_rsp_valid,
  output logic [WORD_W-1:0]     bus_rsp_data,
  input  logic                  core_rd_en,
  input  logic                  core_rd_is_mod,
  input  logic [OPIDX_W-1:0]    core_rd_idx,
  output logic                  core_rd_valid,
  output logic [TOTAL_BITS-1:0] core_rd_data,
  input  logic                  core_wr_en,
  input  logic [OPIDX_W-1:0]    core_wr_idx,
  input  logic [TOTAL_BITS-1:0] core_wr_data
);
  localparam int NWORDS = TOTAL_BITS / WORD_W;

  logic [SLOT_W-1:0] dec_slot;
  logic [WIDX_W-1:0] dec_widx;
  logic              dec_hit;

  omem_addr_dec #(.NWORDS(NWORDS)) dec_i (
    .addr(bus_addr), .slot(dec_slot), .widx(dec_widx), .hit(dec_hit)
  );

  // Core write wins over a processor write to the same operand slot.
  logic collide, accept;
  assign collide = core_wr_en && bus_req_valid && bus_we &&
                   (dec_slot == {1'b0, core_wr_idx});
  assign bus_req_ready = !collide;
  assign accept = bus_req_valid && bus_req_ready;

  logic [WORD_W-1:0]     bank_word [NUM_SLOTS];
  logic [TOTAL_BITS-1:0] bank_full [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic word_we_s, full_we_s;
    assign word_we_s = accept && bus_we && dec_hit && (dec_slot == SLOT_W'(s));
    if (s < NUM_OPS) begin : g_op
      assign full_we_s = core_wr_en && (core_wr_idx == OPIDX_W'(s));
    end else begin : g_mod
      assign full_we_s = 1'b0;
    end
    omem_slot_bank #(.NWORDS(NWORDS)) bank_i (
      .clk(clk), .rst_n(rst_n),
      .word_we(word_we_s), .widx(dec_widx), .word_wdata(bus_wdata),
      .word_q(bank_word[s]),
      .full_we(full_we_s), .full_wdata(core_wr_data), .full_q(bank_full[s])
    );
  end

  // Processor read path
  logic [WORD_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (dec_hit && dec_slot == SLOT_W'(s)) rd_word = bank_word[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rsp_valid <= 1'b0;
      bus_rsp_data  <= '0;
    end else begin
      bus_rsp_valid <= accept && !bus_we;
      if (accept && !bus_we) bus_rsp_data <= rd_word;
    end
  end

  // Core read path
  logic [SLOT_W-1:0]     core_slot;
  logic [TOTAL_BITS-1:0] core_word;
  assign core_slot = core_rd_is_mod ? SLOT_W'(MOD_BASE + int'(mod_sel))
                                    : {1'b0, core_rd_idx};
  always_comb begin
    core_word = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (core_slot == SLOT_W'(s)) core_word = bank_full[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_rd_valid <= 1'b0;
      core_rd_data  <= '0;
    end else begin
      core_rd_valid <= core_rd_en;
      if (core_rd_en) core_rd_data <= core_word;
    end
  end
endmodule

// File: rtl/mod_word_mem_chk.sv
module mod_word_mem_chk
  import omem_pkg::*;
#(
  parameter int TOTAL_BITS = 1536
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req_valid,
  input logic              bus_req_ready,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rsp_valid,
  input logic [WORD_W-1:0] bus_rsp_data,
  input logic              core_rd_en,
  input logic              core_rd_valid,
  input logic              core_wr_en
);
  localparam int NWORDS = TOTAL_BITS / WORD_W;
  logic rd_acc, unmapped;
  assign rd_acc   = bus_req_valid && bus_req_ready && !bus_we;
  assign unmapped = (int'(bus_addr[ADDR_W-1:WIDX_W]) >= NUM_SLOTS) ||
                    (int'(bus_addr[WIDX_W-1:0]) >= NWORDS);

  a_r2_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> bus_rsp_valid);
  a_r2_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !bus_rsp_valid);
  a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && unmapped) |=> (bus_rsp_data == '0));
  a_r5_core_latency: assert property (@(posedge clk) disable iff (!rst_n)
    core_rd_en |=> core_rd_valid);
  a_r5_core_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rd_en |=> !core_rd_valid);
  a_r8_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req_ready |-> (core_wr_en && bus_req_valid && bus_we));
  a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !core_wr_en |-> bus_req_ready);
endmodule

bind mod_word_mem mod_word_mem_chk #(.TOTAL_BITS(TOTAL_BITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_req_valid(bus_req_valid),
  .bus_req_ready(bus_req_ready), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rsp_valid(bus_rsp_valid), .bus_rsp_data(bus_rsp_data),
  .core_rd_en(core_rd_en), .core_rd_valid(core_rd_valid),
  .core_wr_en(core_wr_en)
);

// File: tb/mod_word_mem_tb_top.sv
module mod_word_mem_tb_top;
  localparam int PERIOD = 10;
  localparam int TBITS  = 128;
  localparam int NW     = TBITS / 32;

  logic clk = 0;
  logic rst_n = 0;
  logic mod_sel = 0;
  logic bus_req_valid = 0, bus_we = 0;
  logic [8:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_req_ready, bus_rsp_valid;
  logic [31:0] bus_rsp_data;
  logic core_rd_en = 0, core_rd_is_mod = 0;
  logic [1:0] core_rd_idx = '0;
  logic core_rd_valid;
  logic [TBITS-1:0] core_rd_data;
  logic core_wr_en = 0;
  logic [1:0] core_wr_idx = '0;
  logic [TBITS-1:0] core_wr_data = '0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] model [6][NW];

  always #(PERIOD/2) clk = ~clk;

  mod_word_mem #(.TOTAL_BITS(TBITS)) dut_i (.*);

  task automatic chk(string req, logic [TBITS-1:0] act, logic [TBITS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int s, int w, int salt);
    return (32'(s) << 24) ^ (32'(w) << 12) ^ 32'h5A3C_0F11 ^ 32'(s * 7 + w * 13 + salt);
  endfunction

  function automatic logic [TBITS-1:0] slot_val(int s);
    logic [TBITS-1:0] v;
    for (int w = 0; w < NW; w++) v[32*w +: 32] = model[s][w];
    return v;
  endfunction

  task automatic bus_wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    bus_req_valid = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    while (!bus_req_ready) @(negedge clk);
    @(negedge clk);
    bus_req_valid = 0; bus_we = 0;
  endtask

  task automatic bus_rd(logic [8:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_req_valid = 1; bus_we = 0; bus_addr = a;
    while (!bus_req_ready) @(negedge clk);
    @(negedge clk);
    bus_req_valid = 0;
    d = bus_rsp_data; v = bus_rsp_valid;
  endtask

  task automatic core_rd(logic is_mod, logic [1:0] idx, logic ms,
                         output logic [TBITS-1:0] d, output logic v);
    @(negedge clk);
    core_rd_en = 1; core_rd_is_mod = is_mod; core_rd_idx = idx; mod_sel = ms;
    @(negedge clk);
    core_rd_en = 0;
    d = core_rd_data; v = core_rd_valid;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    logic [TBITS-1:0] wd;
    for (int s = 0; s < 6; s++) for (int w = 0; w < NW; w++) model[s][w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle outputs and cleared contents
    chk("R1 rsp_valid", bus_rsp_valid, 0);
    chk("R1 core_valid", core_rd_valid, 0);
    chk("R1 ready", bus_req_ready, 1);
    for (int s = 0; s < 4; s++) begin
      core_rd(0, 2'(s), 0, wd, v);
      chk("R1 core zero", wd, '0);
    end

    // R3/R4: write every address of every slot code
    for (int s = 0; s < 8; s++) begin
      for (int w = 0; w < 64; w++) begin
        bus_wr({3'(s), 6'(w)}, pat(s, w, 0));
        if (s < 6 && w < NW) model[s][w] = pat(s, w, 0);
      end
    end
    chk("R2 no rsp for write", bus_rsp_valid, 0);
    // R2/R3/R4: read back every address
    for (int s = 0; s < 8; s++) begin
      for (int w = 0; w < 64; w++) begin
        bus_rd({3'(s), 6'(w)}, d, v);
        chk("R2 rsp_valid", v, 1);
        if (s < 6 && w < NW) chk("R3 readback", d, model[s][w]);
        else chk("R4 unmapped zero", d, '0);
      end
    end

    // R5: full operand reads and word placement
    for (int s = 0; s < 4; s++) begin
      core_rd(0, 2'(s), 1, wd, v);
      chk("R5 valid", v, 1);
      chk("R5 operand", wd, slot_val(s));
    end
    // R6: modulus choice, index ignored
    for (int i = 0; i < 4; i++) begin
      core_rd(1, 2'(i), 0, wd, v);
      chk("R6 modulus A", wd, slot_val(4));
      core_rd(1, 2'(i), 1, wd, v);
      chk("R6 modulus B", wd, slot_val(5));
    end

    // R7: full-width core write seen by both ports
    wd = {32'hDEAD_0003, 32'hDEAD_0002, 32'hDEAD_0001, 32'hDEAD_0000};
    @(negedge clk);
    core_wr_en = 1; core_wr_idx = 2; core_wr_data = wd;
    @(negedge clk);
    core_wr_en = 0;
    for (int w = 0; w < NW; w++) model[2][w] = wd[32*w +: 32];
    core_rd(0, 2, 0, wd, v);
    chk("R7 core view", wd, slot_val(2));
    for (int w = 0; w < NW; w++) begin
      bus_rd({3'd2, 6'(w)}, d, v);
      chk("R7 word view", d, model[2][w]);
    end

    // R8: collision on slot 1
    @(negedge clk);
    core_wr_en = 1; core_wr_idx = 1; core_wr_data = {4{32'hC0DE_1111}};
    bus_req_valid = 1; bus_we = 1; bus_addr = {3'd1, 6'd0}; bus_wdata = 32'hB0B0_0001;
    #1;
    chk("R8 ready low on collision", bus_req_ready, 0);
    @(negedge clk);
    core_wr_en = 0;
    #1;
    chk("R8 ready after core write", bus_req_ready, 1);
    @(negedge clk);
    bus_req_valid = 0; bus_we = 0;
    for (int w = 0; w < NW; w++) model[1][w] = 32'hC0DE_1111;
    model[1][0] = 32'hB0B0_0001;
    core_rd(0, 1, 0, wd, v);
    chk("R8 held word lands last", wd, slot_val(1));

    // R9: core write on another slot does not stall
    @(negedge clk);
    core_wr_en = 1; core_wr_idx = 0; core_wr_data = {4{32'h0F0F_2222}};
    bus_req_valid = 1; bus_we = 1; bus_addr = {3'd3, 6'd1}; bus_wdata = 32'h3333_4444;
    #1;
    chk("R9 ready different slot", bus_req_ready, 1);
    @(negedge clk);
    core_wr_en = 0; bus_req_valid = 0; bus_we = 0;
    for (int w = 0; w < NW; w++) model[0][w] = 32'h0F0F_2222;
    model[3][1] = 32'h3333_4444;
    core_rd(0, 0, 0, wd, v);
    chk("R9 core slot 0", wd, slot_val(0));
    core_rd(0, 3, 0, wd, v);
    chk("R9 bus word slot 3", wd, slot_val(3));
    // R9: a read to the slot being core-written is not stalled
    @(negedge clk);
    core_wr_en = 1; core_wr_idx = 3; core_wr_data = '0;
    bus_req_valid = 1; bus_we = 0; bus_addr = {3'd3, 6'd1};
    #1;
    chk("R9 read not stalled", bus_req_ready, 1);
    @(negedge clk);
    core_wr_en = 0; bus_req_valid = 0;
    chk("R9 read old word", bus_rsp_data, 32'h3333_4444);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule